// File: doc/BRIEF.md
# Auto-Acknowledging Priority Interrupt Controller

This controller gathers a parameterised set of level-sensitive interrupt lines and hands them out to several processors through a simple memory-mapped register bus. For every line it keeps a mask bit, a software-trigger bit and a CPU routing mask. A line counts as pending while its hardware input is high or its software-trigger bit is set.

Every bus access carries the number of the CPU that makes it. When a CPU reads the event register, it gets back the lowest-numbered interrupt that is pending, unmasked and routed to it. That same read sets the returned line's mask bit, so the read serves as the acknowledge. Software clears the mask bit again at end of interrupt. Each CPU also has a registered interrupt output, which stays high while at least one deliverable interrupt exists for that CPU.

The register map uses byte addresses:
- Event register: 0x000.
- Software-trigger set bank: 0x100. Software-trigger clear bank: 0x180.
- Mask set bank: 0x200. Mask clear bank: 0x280.
- Routing registers: 0x400 + 4*n.

A read of a set or clear bank word returns the current state of that word.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every software-trigger bit is 0, every routing register reads 1 (CPU 0 only), every CPU output is 0 and the read data is 0.
- R2: A line is pending while its hardware input is high OR its software-trigger bit is 1; the hardware input is level-sensitive, so a line dropped low and not software-triggered is no longer delivered.
- R3: Writing the mask set bank word at 0x200 + 4*(n>>5), or the clear bank word at 0x280 + 4*(n>>5), with bit n&31 at 1 sets or clears mask bit n; data bits at 0 leave their mask bits unchanged; reading either address returns the mask word.
- R4: The software-trigger banks follow the same rule at 0x100 (set) and 0x180 (clear), and read back the same way.
- R5: The routing register of line n sits at 0x400 + 4*n; its bit c enables delivery to CPU c, and a line is never delivered to a CPU whose bit is 0; it reads back as written.
- R6: An event read whose result is an interrupt returns bits 31:24 = 0, bits 23:16 = 1 (hardware interrupt) and bits 15:0 = the line number; all read data appears on the bus the cycle after the read strobe.
- R7: When several lines are deliverable to the reading CPU, the lowest-numbered one is returned.
- R8: An event read that returns line n sets mask bit n in the same cycle, so n is not returned again until it is unmasked.
- R9: An event read with nothing deliverable to the requesting CPU returns all zeros and changes no mask bit.
- R10: Output bit c is registered and equals the OR over all lines of pending AND not masked AND routed to CPU c, one clock after the state it reflects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | NUM_IRQ | Level-sensitive hardware interrupt lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (never together with bus_wr) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Number of the CPU making the access |
| bus_rdata | output | 32 | Read data, registered |
| cpu_irq | output | NUM_CPU | Per-CPU interrupt request |

## Verification
- Read data, including event words, is captured on the clock edge that sees the read strobe. The bench samples it on the following falling edge.
- A register write changes internal state on its own edge. The CPU outputs reflect that change one edge later, so the bench idles one cycle after every operation before it compares all outputs against its model.
- A change on a hardware line reaches the outputs on the first edge after it is driven, which falls inside the same one-cycle wait.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   typedef logic [31:0] word_t;

   localparam logic [31:0] OFS_EVENT = 32'h000;
   localparam logic [31:0] OFS_SWSET = 32'h100;
   localparam logic [31:0] OFS_SWCLR = 32'h180;
   localparam logic [31:0] OFS_MSET  = 32'h200;
   localparam logic [31:0] OFS_MCLR  = 32'h280;
   localparam logic [31:0] OFS_TGT   = 32'h400;
   localparam logic [31:0] BANK_SPAN = 32'h080;
   localparam logic [7:0]  EV_KIND_HW = 8'd1;

   function automatic word_t make_event(input logic [15:0] num);
      return {8'h00, EV_KIND_HW, num};
   endfunction

   function automatic logic in_window(input logic [31:0] a, input logic [31:0] base,
                                      input logic [31:0] span);
      return (a >= base) && (a < base + span) && (a[1:0] == 2'b00);
   endfunction
endpackage

// File: rtl/evt_irq_bitbank.sv
module evt_irq_bitbank #(
   parameter int N         = 40,
   parameter bit RESET_ONE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_we,
   input  logic          clr_we,
   input  logic [15:0]   word_sel,
   input  logic [31:0]   wdata,
   input  logic [N-1:0]  auto_set,
   output logic [N-1:0]  bits_q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic hit;
      logic b_q;
      assign hit = (word_sel == 16'(i / 32)) && wdata[i % 32];
      always_ff @(posedge clk) begin
         if (!rst_n)                          b_q <= RESET_ONE;
         else if ((set_we && hit) || auto_set[i]) b_q <= 1'b1;
         else if (clr_we && hit)              b_q <= 1'b0;
      end
      assign bits_q[i] = b_q;

      // R3 / R4: a set write with a 1 in this bit position leaves the bit high
      assert_set_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (set_we && hit) |=> bits_q[i]);
      // R3 / R4: a clear write with a 0 in this bit position keeps the bit
      assert_zero_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ((set_we || clr_we) && (word_sel == 16'(i / 32)) && !wdata[i % 32] && !auto_set[i])
         |=> bits_q[i] == $past(bits_q[i]));
   end
endmodule

// File: rtl/evt_irq_tgtbank.sv
module evt_irq_tgtbank #(
   parameter int N = 40,
   parameter int C = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [15:0]           idx_sel,
   input  logic [C-1:0]          wdata,
   output logic [N-1:0][C-1:0]   tgt_q
);
   for (genvar i = 0; i < N; i++) begin : g_line
      logic [C-1:0] t_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                          t_q <= C'(1);
         else if (we && idx_sel == 16'(i))    t_q <= wdata;
      end
      assign tgt_q[i] = t_q;
   end
endmodule

// File: rtl/evt_irq_pick.sv
module evt_irq_pick #(
   parameter int N = 40
) (
   input  logic [N-1:0] req,
   output logic         hit,
   output logic [15:0]  idx
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            hit = 1'b1;
            idx = 16'(i);
         end
      end
   end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int NUM_IRQ = 40,
   parameter int NUM_CPU = 4,
   parameter int ADDR_W  = 12,
   parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] hw_irq,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   input  logic [CPU_W-1:0]   bus_cpu,
   output logic [31:0]        bus_rdata,
   output logic [NUM_CPU-1:0] cpu_irq
);
   localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

   if (NUM_IRQ < 1 || NUM_IRQ > 256) begin : g_bad_irq
      $error("NUM_IRQ must lie in 1..256");
   end
   if (NUM_CPU < 1 || NUM_CPU > 32) begin : g_bad_cpu
      $error("NUM_CPU must lie in 1..32");
   end
   if (longint'(OFS_TGT) + 4 * NUM_IRQ > (longint'(1) << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the routing registers");
   end

   logic [31:0] addr32;
   logic sel_sws, sel_swc, sel_ms, sel_mc, sel_tgt, ev_rd;
   logic [15:0] bank_word, tgt_idx;

   assign addr32    = 32'(bus_addr);
   assign sel_sws   = in_window(addr32, OFS_SWSET, BANK_SPAN);
   assign sel_swc   = in_window(addr32, OFS_SWCLR, BANK_SPAN);
   assign sel_ms    = in_window(addr32, OFS_MSET, BANK_SPAN);
   assign sel_mc    = in_window(addr32, OFS_MCLR, BANK_SPAN);
   assign sel_tgt   = in_window(addr32, OFS_TGT, 32'(4 * NUM_IRQ));
   assign ev_rd     = bus_rd && (addr32 == OFS_EVENT);
   assign bank_word = 16'(addr32[6:2]);
   assign tgt_idx   = 16'((addr32 - OFS_TGT) >> 2);

   logic [NUM_IRQ-1:0] sw_q, mask_q, pend, cand, auto_set;
   logic [NUM_IRQ-1:0][NUM_CPU-1:0] tgt_q;
   logic        pick_hit;
   logic [15:0] pick_idx;

   evt_irq_bitbank #(.N(NUM_IRQ), .RESET_ONE(1'b0)) i_swbank (
      .clk(clk), .rst_n(rst_n), .set_we(bus_wr && sel_sws), .clr_we(bus_wr && sel_swc),
      .word_sel(bank_word), .wdata(bus_wdata), .auto_set('0), .bits_q(sw_q));

   evt_irq_bitbank #(.N(NUM_IRQ), .RESET_ONE(1'b1)) i_maskbank (
      .clk(clk), .rst_n(rst_n), .set_we(bus_wr && sel_ms), .clr_we(bus_wr && sel_mc),
      .word_sel(bank_word), .wdata(bus_wdata), .auto_set(auto_set), .bits_q(mask_q));

   evt_irq_tgtbank #(.N(NUM_IRQ), .C(NUM_CPU)) i_tgtbank (
      .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_tgt), .idx_sel(tgt_idx),
      .wdata(bus_wdata[NUM_CPU-1:0]), .tgt_q(tgt_q));

   assign pend = hw_irq | sw_q;

   always_comb begin
      for (int i = 0; i < NUM_IRQ; i++) begin
         cand[i] = pend[i] && !mask_q[i] &&
                   (32'(bus_cpu) < NUM_CPU) && tgt_q[i][bus_cpu];
      end
   end

   evt_irq_pick #(.N(NUM_IRQ)) i_pick (.req(cand), .hit(pick_hit), .idx(pick_idx));

   always_comb begin
      auto_set = '0;
      if (ev_rd && pick_hit) auto_set[pick_idx[IDX_W-1:0]] = 1'b1;
   end

   function automatic word_t pack_word(input logic [NUM_IRQ-1:0] v, input logic [15:0] w);
      word_t r = '0;
      for (int b = 0; b < 32; b++) begin
         if (int'(w) * 32 + b < NUM_IRQ) r[b] = v[int'(w) * 32 + b];
      end
      return r;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else if (bus_rd) begin
         if (ev_rd)                bus_rdata <= pick_hit ? make_event(pick_idx) : '0;
         else if (sel_sws || sel_swc) bus_rdata <= pack_word(sw_q, bank_word);
         else if (sel_ms || sel_mc)   bus_rdata <= pack_word(mask_q, bank_word);
         else if (sel_tgt)         bus_rdata <= 32'(tgt_q[tgt_idx[IDX_W-1:0]]);
         else                      bus_rdata <= '0;
      end
   end

   logic [NUM_CPU-1:0] live_any;
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_IRQ-1:0] live;
      always_comb begin
         for (int i = 0; i < NUM_IRQ; i++) live[i] = pend[i] && !mask_q[i] && tgt_q[i][c];
      end
      assign live_any[c] = |live;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cpu_irq <= '0;
      else        cpu_irq <= live_any;
   end

   assert_ack_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && pick_hit) |=> mask_q[$past(pick_idx[IDX_W-1:0])]);
   assert_event_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && pick_hit) |=> (bus_rdata[31:16] == 16'h0001) &&
                              (bus_rdata[15:0] == $past(pick_idx)));
   assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && !pick_hit) |=> (bus_rdata == '0) && $stable(mask_q));
   assert_pick_member_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pick_hit |-> (cand[pick_idx[IDX_W-1:0]] && !mask_q[pick_idx[IDX_W-1:0]]));
   assert_all_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |=> (cpu_irq == '0));
endmodule

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
   localparam int N = 40;
   localparam int C = 4;
   localparam int CW = 2;
   localparam int A_SWS = 'h100, A_SWC = 'h180, A_MS = 'h200, A_MC = 'h280, A_TG = 'h400;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0] hw_irq = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [CW-1:0] bus_cpu = '0;
   logic [31:0] bus_rdata;
   logic [C-1:0] cpu_irq;

   always #5 clk = ~clk;

   evt_irq_ctrl i_evt_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
      .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

   int n_cmp = 0, n_bad = 0;
   bit [N-1:0] m_mask, m_sw, m_hw;
   bit [C-1:0] m_tgt [N];
   logic [31:0] rd;

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_event(input int cpu);
      for (int i = 0; i < N; i++)
         if ((m_hw[i] | m_sw[i]) && !m_mask[i] && m_tgt[i][cpu]) return {16'h0001, 16'(i)};
      return '0;
   endfunction

   function automatic logic [C-1:0] exp_irq();
      logic [C-1:0] r = '0;
      for (int c = 0; c < C; c++)
         for (int i = 0; i < N; i++)
            if ((m_hw[i] | m_sw[i]) && !m_mask[i] && m_tgt[i][c]) r[c] = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] word_of(input bit [N-1:0] v, input int w);
      logic [31:0] r = '0;
      for (int b = 0; b < 32; b++) if (w * 32 + b < N) r[b] = v[w * 32 + b];
      return r;
   endfunction

   function automatic void model_write(input int a, input logic [31:0] d);
      for (int b = 0; b < 32; b++) begin
         if (a >= A_SWS && a < A_MC + 'h80 && d[b]) begin
            int n = ((a & 'h7F) >> 2) * 32 + b;
            if (n < N) begin
               if (a < A_SWC)      m_sw[n] = 1'b1;
               else if (a < A_MS)  m_sw[n] = 1'b0;
               else if (a < A_MC)  m_mask[n] = 1'b1;
               else                m_mask[n] = 1'b0;
            end
         end
      end
      if (a >= A_TG && a < A_TG + 4 * N) m_tgt[(a - A_TG) >> 2] = d[C-1:0];
   endfunction

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic bus_write(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(input int a, input int cpu, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 12'(a); bus_cpu = CW'(cpu);
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic event_read(input int cpu, input string tag);
      logic [31:0] exp = exp_event(cpu);
      bus_read(0, cpu, rd);
      check(rd, exp, tag);
      if (exp != 0) m_mask[exp[15:0]] = 1'b1;
   endtask

   task automatic check_irq(input string tag);
      idle();
      check(32'(cpu_irq), 32'(exp_irq()), tag);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      report();
   end

   initial begin
      m_mask = '1; m_sw = '0; m_hw = '0;
      for (int i = 0; i < N; i++) m_tgt[i] = C'(1);
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R1 reset state
      check(32'(cpu_irq), 0, "R1 cpu_irq");
      check(bus_rdata, 0, "R1 rdata");
      bus_read(A_MS, 0, rd);      check(rd, 32'hFFFF_FFFF, "R1 mask word0");
      bus_read(A_MC + 4, 0, rd);  check(rd, 32'h0000_00FF, "R1 mask word1");
      bus_read(A_SWS, 0, rd);     check(rd, 0, "R1 sw word0");
      bus_read(A_TG + 4 * 7, 0, rd); check(rd, 1, "R1 target 7");
      event_read(0, "R9 empty after reset");

      // R4 + R3: software trigger lines 3 and 5, unmask them
      bus_write(A_SWS, 32'h28);
      bus_read(A_SWC, 0, rd); check(rd, 32'h28, "R4 sw readback");
      bus_write(A_MC, 32'h28);
      check_irq("R10 after unmask");
      event_read(1, "R5 cpu1 not routed");
      event_read(0, "R7 lowest first (3)");
      bus_read(A_MS, 0, rd); check(rd, word_of(m_mask, 0), "R8 mask set by ack");
      event_read(0, "R6 second event (5)");
      event_read(0, "R9 nothing left");
      bus_read(A_MS, 0, rd); check(rd, word_of(m_mask, 0), "R9 mask unchanged");
      check_irq("R10 all acked");

      // R2 hardware path, R5 routing to cpu2
      bus_write(A_SWC, 32'h28);
      @(negedge clk); hw_irq[33] = 1'b1; m_hw[33] = 1'b1;
      bus_write(A_TG + 4 * 33, 32'h4);
      bus_read(A_TG + 4 * 33, 0, rd); check(rd, 32'h4, "R5 target readback");
      bus_write(A_MC + 4, 32'h2);
      check_irq("R2 hw line to cpu2");
      event_read(2, "R6 hw event 33");
      bus_write(A_MC, 32'h0);
      bus_read(A_MS, 0, rd); check(rd, word_of(m_mask, 0), "R3 zero write ignored");
      bus_write(A_MC + 4, 32'h2);
      @(negedge clk); hw_irq[33] = 1'b0; m_hw[33] = 1'b0;
      check_irq("R2 level dropped");

      // random phase
      for (int it = 0; it < 400; it++) begin
         int op = int'($urandom_range(0, 7));
         int w  = int'($urandom_range(0, 1));
         case (op)
            0: begin
               @(negedge clk);
               m_hw = {$urandom, $urandom} & {$urandom, $urandom};
               hw_irq = m_hw;
            end
            1: bus_write(A_SWS + 4 * w, $urandom & $urandom);
            2: bus_write(A_SWC + 4 * w, $urandom);
            3: bus_write(A_MS + 4 * w, $urandom & $urandom & $urandom);
            4: bus_write(A_MC + 4 * w, $urandom);
            5: bus_write(A_TG + 4 * int'($urandom_range(0, N - 1)), $urandom);
            6: event_read(int'($urandom_range(0, C - 1)), "R7 random event");
            default: begin
               bus_read(A_MS + 4 * w, 0, rd); check(rd, word_of(m_mask, w), "R3 random mask");
               bus_read(A_SWC + 4 * w, 0, rd); check(rd, word_of(m_sw, w), "R4 random sw");
            end
         endcase
         check_irq("R10 random outputs");
      end
      report();
   end
endmodule